// File: doc/BRIEF.md
# Programmable 16-bit Down-Counting Timer

This block is a 16-bit down-counter driven through a small byte-wide register port. Software writes a terminal count N into two reload byte registers, picks an operating mode and a clock source, and then issues a start command. The timer counts N ticks and then expires. In one-shot mode the expiry drives the timer output high once and the timer halts. In periodic mode the timer reloads N on every expiry and toggles its output, so the output is a square wave with a half-period of N ticks until software stops it.

Commands are written as 4-bit codes into a control register. The command field is self-clearing: it always reads back as zero, while the upper bits of the same register report the live state. Every expiry latches a pending interrupt that stays high until software reads the interrupt status register. A tick is either every cycle of the system clock or each rising edge of an external timer clock that has been brought through a two-flop synchronizer.

The register port has no data stream, so there is no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `wr_en` is high. A read returns data combinationally from `rd_addr`, and the side effect of a read happens at the edge where `rd_en` is high.

Top module: `prog_timer16`

## Requirements
- R1: After reset the timer output and interrupt are low, the timer is stopped in one-shot mode with the internal clock, and all four registers read zero.
- R2: Address 0 holds bits 7:0 and address 1 holds bits 15:8 of the reload value N, and both read back what was written.
- R3: A write to address 2 decodes bits 3:0 as follows: 1 start, 2 stop, 3 one-shot, 4 periodic, 5 internal clock, 6 external clock, 7 reset timer. All other codes (0 and 8 to 15) change nothing. Reads of address 2 return bits 3:0 as zero, bit 4 as running, bit 5 as periodic mode and bit 6 as external clock selected.
- R4: In one-shot mode a start loads N and drives the output low. The output goes high on the Nth tick after the start edge, the timer stops, and the output stays high.
- R5: In periodic mode the output toggles on every Nth tick after the start edge, and the timer keeps running.
- R6: A stop command halts counting and forces the output low. A later start counts a full N again.
- R7: A reload value of zero counts 65536 ticks before expiry.
- R8: With the external clock selected, only rising edges of the synchronized external input decrement the count, and system-clock cycles do not.
- R9: Every expiry sets the pending interrupt, which drives `tmr_irq`. A read of address 3 returns the pending flag in bit 0 and clears it, unless an expiry occurs at the same edge, in which case the flag stays set.
- R10: The reset-timer command stops the timer, drives the output low and clears the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read strobe; enables the read side effects |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Combinational read data |
| ext_tmr_clk | input | 1 | Asynchronous external timer clock |
| tmr_out | output | 1 | Timer output |
| tmr_irq | output | 1 | Pending timer interrupt |

## Verification
The bench targets the count boundary. A design that is off by one would expire at N-1 or N+1 ticks, and a design that treats zero literally would expire at once instead of after 65536 ticks. It reads the interrupt status at exactly the edge where a periodic expiry lands. A design that lets the clear win would lose that interrupt. It feeds slow external clock pulses while many system cycles pass, which exposes a design that still counts internal cycles. It also checks that writes of unused codes leave the mode bits, output and interrupt unchanged, and that a restart after a stop counts a full N rather than resuming the frozen count.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int CMD_W    = 4;
  localparam int RUN_BIT  = 4;
  localparam int MODE_BIT = 5;
  localparam int SRC_BIT  = 6;

  localparam logic [CMD_W-1:0] CMD_START    = 4'h1;
  localparam logic [CMD_W-1:0] CMD_STOP     = 4'h2;
  localparam logic [CMD_W-1:0] CMD_ONESHOT  = 4'h3;
  localparam logic [CMD_W-1:0] CMD_PERIODIC = 4'h4;
  localparam logic [CMD_W-1:0] CMD_CLK_INT  = 4'h5;
  localparam logic [CMD_W-1:0] CMD_CLK_EXT  = 4'h6;
  localparam logic [CMD_W-1:0] CMD_RESET    = 4'h7;

  // one-hot decoded command strobe, all zero when no valid code was written
  typedef struct packed {
    logic start;
    logic stop;
    logic reset;
    logic oneshot;
    logic periodic;
    logic clk_int;
    logic clk_ext;
  } tmr_cmd_t;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  reload,
  output tmr_cmd_t          cmd
);
  localparam int BYTES = CNT_W / DATA_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BYTES);

  // one byte-wide reload register per address
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reload[b*DATA_W +: DATA_W] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(b)) begin
        reload[b*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end

  // command codes exist only for the write cycle, so nothing is stored
  always_comb begin
    cmd = '0;
    if (wr_en && wr_addr == CTRL_ADDR) begin
      case (wr_data[CMD_W-1:0])
        CMD_START:    cmd.start    = 1'b1;
        CMD_STOP:     cmd.stop     = 1'b1;
        CMD_ONESHOT:  cmd.oneshot  = 1'b1;
        CMD_PERIODIC: cmd.periodic = 1'b1;
        CMD_CLK_INT:  cmd.clk_int  = 1'b1;
        CMD_CLK_EXT:  cmd.clk_ext  = 1'b1;
        CMD_RESET:    cmd.reset    = 1'b1;
        default:      cmd          = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptmr_tick.sv
module ptmr_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic ext_sel,
  output logic tick
);
  // SYNC_STAGES synchronizer flops followed by one history flop
  logic [SYNC_STAGES:0] shift_q;
  logic                 ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
  assign tick     = ext_sel ? ext_rise : 1'b1;
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  output logic             running,
  output logic             retrig,
  output logic             ext_sel,
  output logic             tmr_out,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic halt_cmd;
  logic last;

  assign halt_cmd = cmd.start | cmd.stop | cmd.reset;
  // a load of zero wraps through all ones, so it lasts 2**CNT_W ticks
  assign last     = (cnt_q == ONE);
  assign expire   = running & tick & last & ~halt_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      running <= 1'b0;
      retrig  <= 1'b0;
      ext_sel <= 1'b0;
      tmr_out <= 1'b0;
    end else begin
      if (cmd.oneshot)       retrig <= 1'b0;
      else if (cmd.periodic) retrig <= 1'b1;

      if (cmd.clk_int)      ext_sel <= 1'b0;
      else if (cmd.clk_ext) ext_sel <= 1'b1;

      if (cmd.start) begin
        cnt_q   <= reload;
        running <= 1'b1;
        tmr_out <= 1'b0;
      end else if (cmd.stop) begin
        running <= 1'b0;
        tmr_out <= 1'b0;
      end else if (cmd.reset) begin
        cnt_q   <= reload;
        running <= 1'b0;
        tmr_out <= 1'b0;
      end else if (running && tick) begin
        if (last) begin
          if (retrig) begin
            cnt_q   <= reload;
            tmr_out <= ~tmr_out;
          end else begin
            running <= 1'b0;
            tmr_out <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic rd_clear,
  input  logic cmd_reset,
  output logic pending
);
  // a new expiry outranks a clear at the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pending <= 1'b0;
    else if (expire)                 pending <= 1'b1;
    else if (rd_clear || cmd_reset)  pending <= 1'b0;
  end
endmodule

// File: rtl/prog_timer16.sv
module prog_timer16
  import ptmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(CNT_W / DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_tmr_clk,
  output logic              tmr_out,
  output logic              tmr_irq
);
  localparam int BYTES = CNT_W / DATA_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BYTES);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(BYTES + 1);

  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt_q;
  tmr_cmd_t         cmd;
  logic             tick, running, retrig, ext_sel, expire, rd_clear;

  ptmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload(reload), .cmd(cmd)
  );

  ptmr_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_tmr_clk), .ext_sel(ext_sel), .tick(tick)
  );

  ptmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .reload(reload), .tick(tick),
    .running(running), .retrig(retrig), .ext_sel(ext_sel),
    .tmr_out(tmr_out), .expire(expire), .cnt_q(cnt_q)
  );

  assign rd_clear = rd_en && (rd_addr == STAT_ADDR);

  ptmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .rd_clear(rd_clear),
    .cmd_reset(cmd.reset), .pending(tmr_irq)
  );

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (rd_addr == ADDR_W'(b)) rd_data = reload[b*DATA_W +: DATA_W];
    end
    if (rd_addr == CTRL_ADDR) begin
      rd_data[RUN_BIT]  = running;
      rd_data[MODE_BIT] = retrig;
      rd_data[SRC_BIT]  = ext_sel;
    end
    if (rd_addr == STAT_ADDR) rd_data[0] = tmr_irq;
  end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              tmr_out,
  input logic              tmr_irq,
  input logic              running,
  input logic              retrig,
  input logic              expire,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CNT_W / DATA_W);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(CNT_W / DATA_W + 1);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  p_cmd_field_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == CTRL_ADDR) |-> (rd_data[CMD_W-1:0] == '0));

  p_oneshot_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !retrig) |=> (!running && tmr_out));

  p_periodic_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && retrig) |=> (running && (tmr_out != $past(tmr_out))));

  p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[CMD_W-1:0] == CMD_STOP) |=> (!running && !tmr_out));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ctrl_wr) |=> $stable(cnt_q));

  p_expiry_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmr_irq);

  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == STAT_ADDR && !expire) |=> !tmr_irq);
endmodule

bind prog_timer16 ptmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tmr_out(tmr_out),
  .tmr_irq(tmr_irq), .running(running), .retrig(retrig), .expire(expire),
  .cnt_q(cnt_q)
);

// File: tb/prog_timer16_test.sv
`timescale 1ns/1ps
module prog_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, ext_tmr_clk;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       tmr_out, tmr_irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  prog_timer16 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ext_tmr_clk(ext_tmr_clk),
    .tmr_out(tmr_out), .tmr_irq(tmr_irq)
  );

  // expected output k ticks after the start edge
  function automatic logic exp_out(input logic per, input int n, input int k);
    if (per) return ((k / n) % 2) == 1;
    return k >= n;
  endfunction

  function automatic logic exp_irq(input int n, input int k);
    return k >= n;
  endfunction

  function automatic logic [7:0] ctrl_word(input logic run, input logic per, input logic ext);
    return {1'b0, ext, per, run, 4'b0000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    step();
    rd_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] n);
    wr(2'd0, n[7:0]);
    wr(2'd1, n[15:8]);
  endtask

  task automatic ext_pulse();
    ext_tmr_clk = 1'b1;
    repeat (3) step();
    ext_tmr_clk = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ext_tmr_clk = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 out", tmr_out, 0);
    chk("R1 irq", tmr_irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", d, 0);
    end

    // R2 reload bytes
    load(16'hA55A);
    rd(2'd0, d); chk("R2 low byte", d, 8'h5A);
    rd(2'd1, d); chk("R2 high byte", d, 8'hA5);

    // R3 command field reads zero, unused codes ignored
    wr(2'd2, 8'h04);
    rd(2'd2, d); chk("R3 periodic bit", d, ctrl_word(0, 1, 0));
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h09);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk("R3 unused codes", d, ctrl_word(0, 1, 0));
    chk("R3 unused out", tmr_out, 0);
    chk("R3 unused irq", tmr_irq, 0);
    rd(2'd0, d); chk("R3 unused reload", d, 8'h5A);
    wr(2'd2, 8'hF3);
    rd(2'd2, d); chk("R3 one-shot select", d, ctrl_word(0, 0, 0));

    // R4 directed one-shot N=5
    load(16'd5);
    wr(2'd2, 8'h01);
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R4 one-shot out", tmr_out, exp_out(0, 5, k));
      chk("R9 one-shot irq", tmr_irq, exp_irq(5, k));
    end
    rd(2'd2, d); chk("R4 halted", d, ctrl_word(0, 0, 0));

    // R10 reset command
    wr(2'd2, 8'h07);
    chk("R10 out low", tmr_out, 0);
    chk("R10 irq cleared", tmr_irq, 0);

    // R9 read colliding with a periodic expiry, R5 toggle
    load(16'd5);
    wr(2'd2, 8'h04);
    wr(2'd2, 8'h01);
    repeat (9) step();
    chk("R9 pending", tmr_irq, 1);
    rd(2'd3, d);
    chk("R9 status bit", d, 1);
    chk("R9 expiry beats clear", tmr_irq, 1);
    chk("R5 toggle back", tmr_out, 0);
    rd(2'd3, d);
    chk("R9 read clears", tmr_irq, 0);
    repeat (4) step();
    chk("R9 set again", tmr_irq, 1);
    chk("R5 toggle high", tmr_out, 1);

    // R6 stop and restart
    wr(2'd2, 8'h02);
    chk("R6 stop out", tmr_out, 0);
    rd(2'd2, d); chk("R6 stopped", d, ctrl_word(0, 1, 0));
    repeat (20) step();
    chk("R6 still low", tmr_out, 0);
    rd(2'd3, d);
    wr(2'd2, 8'h01);
    repeat (4) step();
    chk("R6 full N pre", tmr_out, 0);
    step();
    chk("R6 full N", tmr_out, 1);
    wr(2'd2, 8'h07);

    // R7 N=0 counts 65536 ticks
    load(16'd0);
    wr(2'd2, 8'h03);
    wr(2'd2, 8'h01);
    repeat (65535) step();
    chk("R7 before wrap", tmr_out, 0);
    step();
    chk("R7 expiry", tmr_out, 1);
    chk("R7 irq", tmr_irq, 1);
    wr(2'd2, 8'h07);

    // R8 external clock
    load(16'd3);
    wr(2'd2, 8'h06);
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R8 ext selected", d, ctrl_word(1, 0, 1));
    repeat (10) step();
    chk("R8 internal ignored", tmr_out, 0);
    ext_pulse();
    ext_pulse();
    chk("R8 two edges", tmr_out, 0);
    ext_pulse();
    chk("R8 third edge", tmr_out, 1);
    chk("R8 irq", tmr_irq, 1);
    wr(2'd2, 8'h05);
    wr(2'd2, 8'h07);

    // R4 R5 random reload values and modes
    for (int t = 0; t < 25; t++) begin
      int   n;
      logic per;
      n   = int'($urandom_range(1, 40));
      per = 1'($urandom_range(0, 1));
      load(16'(n));
      wr(2'd2, per ? 8'h04 : 8'h03);
      wr(2'd2, 8'h01);
      for (int k = 1; k <= 3 * n + 3; k++) begin
        step();
        chk(per ? "R5 random out" : "R4 random out", tmr_out, exp_out(per, n, k));
        chk("R9 random irq", tmr_irq, exp_irq(n, k));
      end
      wr(2'd2, 8'h07);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule